// File: doc/BRIEF.md
# Configuration-Controlled Fault Decision Unit

This block keeps a 32-bit configuration control word that software writes through a simple register port. It uses that word to decide what happens to events reported by a processor pipeline: a load or store with its size and low address bits, a divide whose divisor may be zero, and a data bus error seen at a given execution priority. For each event it either lets execution continue, raises a usage-fault request and records a sticky cause flag, selects a forced-zero quotient, marks a bus error to be ignored, passes the bus error on as a normal bus fault, or requests processor lockup.

The bus-error path is a two-state machine. In state `LK_RUN`, an escalated bus error arrives with a negative priority. If the ignore enable is clear, the machine takes the transition `RUN->HALT` into state `LK_HALT`. If the ignore enable is set, it stays in `LK_RUN` and pulses the ignore output. A bus error at priority zero or above stays in `LK_RUN` and pulses the bus-fault request. `LK_HALT` holds the lockup request and has only the self-transition `HALT->HALT`. Only reset leaves it. All fault outputs and flags are registered, so they appear one cycle after the event. The quotient select is combinational, so the divider can use it in the same cycle.

Top module: `fault_cfg_unit`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00000200: only bit 9 (stack alignment) is set. All fault outputs and cause flags are 0.
- R2: A write with `reg_we` high updates the register on that clock edge. Bits 9, 8, 4, 3, 1 and 0 are writable. Every other bit position is discarded and always reads 0.
- R3: `acc_size` encodes 0 as byte, 1 as halfword and 2 as word. A byte access is never unaligned. A halfword is unaligned when address bit 0 is 1. A word is unaligned when address bits 1:0 are non-zero. With config bit 3 set, an unaligned access raises `uf_req` one cycle later and sets `uf_cause[0]`. With bit 3 clear, it raises nothing.
- R4: With `acc_multi` high (a multi-word or doubleword transfer), the access is unaligned when address bits 1:0 are non-zero. It then always raises `uf_req` and sets `uf_cause[0]`, whatever bit 3 holds.
- R5: A divide with a zero divisor while config bit 4 is clear drives `quot_zero` high in the same cycle and raises no fault. A divide with a non-zero divisor never drives `quot_zero`.
- R6: A divide with a zero divisor while bit 4 is set raises `uf_req` one cycle later and sets `uf_cause[1]`. In this case `quot_zero` stays low.
- R7: The bits of `uf_cause` stay set until a 1 is written to the matching bit of `cause_clr`. If a bit is set and cleared in the same cycle, the set wins.
- R8: `uf_req` is high for exactly one cycle for each cycle that carries a faulting event.
- R9: A bus error at negative priority (-1 or -2) with config bit 8 clear raises `lockup` one cycle later. `lockup` stays high until reset. While locked, further bus errors produce no ignore or bus-fault pulse.
- R10: A bus error at negative priority with bit 8 set pulses `berr_ignore` for one cycle and leaves `lockup` low.
- R11: A bus error at priority 0 or above pulses `bus_fault_req` for one cycle, whatever bit 8 holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current configuration word |
| acc_valid | input | 1 | Load/store access present |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_addr_lo | input | 2 | Address bits 1:0 of the access |
| acc_multi | input | 1 | Multi-word or doubleword transfer |
| div_valid | input | 1 | Divide operation present |
| div_zero | input | 1 | Divisor is zero |
| berr_valid | input | 1 | Data bus error from a load or store |
| exec_prio | input | 8 | Current execution priority, signed |
| cause_clr | input | 2 | Write-one-to-clear for the cause flags |
| uf_req | output | 1 | Usage-fault request pulse |
| uf_cause | output | 2 | Sticky causes: bit 0 unaligned, bit 1 divide-by-zero |
| berr_ignore | output | 1 | Bus error ignored pulse |
| bus_fault_req | output | 1 | Normal bus-fault request pulse |
| lockup | output | 1 | Lockup request |
| quot_zero | output | 1 | Force the divide result to zero |

## Verification
A stuck or wrong configuration bit first shows on `reg_rdata`. One cycle after the next relevant event, it also shows as a missing or extra `uf_req`, `berr_ignore` or `lockup`. A bus-error machine that leaves `LK_HALT` shows as `lockup` dropping in the cycle after the fault. A wrong sticky flag shows on `uf_cause` in every cycle until the next clear. For that reason, every scoreboard entry compares the full output set, including the flags, in the cycle after each stimulus.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    localparam int          CFG_W     = 32;
    localparam logic [31:0] CFG_RST   = 32'h0000_0200;
    localparam logic [31:0] CFG_WMASK = 32'h0000_031B;

    // bit positions decoded by the fault logic
    localparam int BIT_UA_TRAP = 3;
    localparam int BIT_DZ_TRAP = 4;
    localparam int BIT_BE_SKIP = 8;

    // cause flag positions
    localparam int CZ_UA = 0;
    localparam int CZ_DZ = 1;
    localparam int CZ_W  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        LK_RUN  = 1'b0,
        LK_HALT = 1'b1
    } lk_state_e;

endpackage

// File: rtl/fcu_cfg_reg.sv
module fcu_cfg_reg #(
    parameter int          W     = 32,
    parameter logic [31:0] RST   = 32'h0000_0200,
    parameter logic [31:0] WMASK = 32'h0000_031B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (WMASK[i]) begin : g_store
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)  bit_q <= RST[i];
                else if (we) bit_q <= wdata[i];
            end
            assign q[i] = bit_q;
        end else begin : g_rsvd
            assign q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/fcu_align_chk.sv
module fcu_align_chk
    import fcu_pkg::*;
#(
    parameter int ALO_W = 2
) (
    input  logic             valid,
    input  logic [1:0]       size,
    input  logic [ALO_W-1:0] addr_lo,
    input  logic             multi,
    output logic             misaligned,
    output logic             forced
);

    logic half_bad;
    logic word_bad;

    always_comb begin
        half_bad = addr_lo[0];
        word_bad = |addr_lo;
        misaligned = 1'b0;
        if (valid) begin
            if (multi) begin
                misaligned = word_bad;
            end else begin
                unique case (acc_size_e'(size))
                    SZ_BYTE: misaligned = 1'b0;
                    SZ_HALF: misaligned = half_bad;
                    SZ_WORD: misaligned = word_bad;
                    default: misaligned = 1'b0;
                endcase
            end
        end
        forced = valid && multi;
    end

endmodule

// File: rtl/fcu_usage_ctrl.sv
module fcu_usage_ctrl
    import fcu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            misaligned,
    input  logic            forced,
    input  logic            ua_trap_en,
    input  logic            div_valid,
    input  logic            div_zero,
    input  logic            dz_trap_en,
    input  logic [CZ_W-1:0] clr,
    output logic            uf_req,
    output logic [CZ_W-1:0] cause,
    output logic            quot_zero
);

    logic            ua_fault;
    logic            dz_fault;
    logic [CZ_W-1:0] hit;

    always_comb begin
        ua_fault      = misaligned && (forced || ua_trap_en);
        dz_fault      = div_valid && div_zero && dz_trap_en;
        quot_zero     = div_valid && div_zero && !dz_trap_en;
        hit           = '0;
        hit[CZ_UA]    = ua_fault;
        hit[CZ_DZ]    = dz_fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_req <= 1'b0;
            cause  <= '0;
        end else begin
            uf_req <= |hit;
            cause  <= (cause & ~clr) | hit;
        end
    end

endmodule

// File: rtl/fcu_berr_fsm.sv
module fcu_berr_fsm
    import fcu_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              berr_valid,
    input  logic [PRIO_W-1:0] prio,
    input  logic              skip_en,
    output logic              ignore,
    output logic              fault_req,
    output logic              lockup
);

    lk_state_e state_q;
    lk_state_e state_d;
    logic      escalated;
    logic      ign_d;
    logic      flt_d;

    assign escalated = prio[PRIO_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ign_d   = 1'b0;
        flt_d   = 1'b0;
        unique case (state_q)
            LK_RUN: begin
                if (berr_valid) begin
                    if (!escalated)  flt_d   = 1'b1;
                    else if (skip_en) ign_d  = 1'b1;
                    else             state_d = LK_HALT;
                end
            end
            LK_HALT: state_d = LK_HALT;
            default: state_d = LK_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ignore    <= 1'b0;
            fault_req <= 1'b0;
        end else begin
            ignore    <= ign_d;
            fault_req <= flt_d;
        end
    end

    assign lockup = (state_q == LK_HALT);

endmodule

// File: rtl/fault_cfg_unit.sv
module fault_cfg_unit
    import fcu_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ALO_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_size,
    input  logic [ALO_W-1:0]  acc_addr_lo,
    input  logic              acc_multi,
    input  logic              div_valid,
    input  logic              div_zero,
    input  logic              berr_valid,
    input  logic [PRIO_W-1:0] exec_prio,
    input  logic [1:0]        cause_clr,
    output logic              uf_req,
    output logic [1:0]        uf_cause,
    output logic              berr_ignore,
    output logic              bus_fault_req,
    output logic              lockup,
    output logic              quot_zero
);

    logic [CFG_W-1:0] cfg;
    logic             misaligned;
    logic             forced;

    fcu_cfg_reg #(
        .W     (CFG_W),
        .RST   (CFG_RST),
        .WMASK (CFG_WMASK)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .q     (cfg)
    );

    fcu_align_chk #(.ALO_W(ALO_W)) u_align (
        .valid      (acc_valid),
        .size       (acc_size),
        .addr_lo    (acc_addr_lo),
        .multi      (acc_multi),
        .misaligned (misaligned),
        .forced     (forced)
    );

    fcu_usage_ctrl u_usage (
        .clk        (clk),
        .rst_n      (rst_n),
        .misaligned (misaligned),
        .forced     (forced),
        .ua_trap_en (cfg[BIT_UA_TRAP]),
        .div_valid  (div_valid),
        .div_zero   (div_zero),
        .dz_trap_en (cfg[BIT_DZ_TRAP]),
        .clr        (cause_clr),
        .uf_req     (uf_req),
        .cause      (uf_cause),
        .quot_zero  (quot_zero)
    );

    fcu_berr_fsm #(.PRIO_W(PRIO_W)) u_berr (
        .clk        (clk),
        .rst_n      (rst_n),
        .berr_valid (berr_valid),
        .prio       (exec_prio),
        .skip_en    (cfg[BIT_BE_SKIP]),
        .ignore     (berr_ignore),
        .fault_req  (bus_fault_req),
        .lockup     (lockup)
    );

    assign reg_rdata = cfg;

endmodule

// File: rtl/fcu_checker.sv
module fcu_checker
    import fcu_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ALO_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       reg_rdata,
    input logic              acc_valid,
    input logic [ALO_W-1:0]  acc_addr_lo,
    input logic              acc_multi,
    input logic              div_valid,
    input logic              div_zero,
    input logic              uf_req,
    input logic [1:0]        uf_cause,
    input logic              berr_ignore,
    input logic              bus_fault_req,
    input logic              lockup,
    input logic              quot_zero
);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~CFG_WMASK) == 32'h0);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> lockup);

    // R6
    dz_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && div_zero && reg_rdata[BIT_DZ_TRAP]) |=> (uf_req && uf_cause[CZ_DZ]));

    // R5
    qz_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quot_zero |-> (div_valid && div_zero && !reg_rdata[BIT_DZ_TRAP]));

    // R4
    multi_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_multi && (acc_addr_lo != '0)) |=> (uf_req && uf_cause[CZ_UA]));

    // R10
    ignore_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_ignore |-> (!bus_fault_req && !lockup));

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf_cause[CZ_UA]) |-> uf_req);

endmodule

bind fault_cfg_unit fcu_checker #(.PRIO_W(PRIO_W), .ALO_W(ALO_W)) u_fcu_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rdata     (reg_rdata),
    .acc_valid     (acc_valid),
    .acc_addr_lo   (acc_addr_lo),
    .acc_multi     (acc_multi),
    .div_valid     (div_valid),
    .div_zero      (div_zero),
    .uf_req        (uf_req),
    .uf_cause      (uf_cause),
    .berr_ignore   (berr_ignore),
    .bus_fault_req (bus_fault_req),
    .lockup        (lockup),
    .quot_zero     (quot_zero)
);

// File: tb/test_fault_cfg_unit.sv
module test_fault_cfg_unit;

    localparam logic [31:0] MASK = 32'h0000_031B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_addr_lo = '0;
    logic        acc_multi = 1'b0;
    logic        div_valid = 1'b0;
    logic        div_zero = 1'b0;
    logic        berr_valid = 1'b0;
    logic [7:0]  exec_prio = '0;
    logic [1:0]  cause_clr = '0;
    logic        uf_req;
    logic [1:0]  uf_cause;
    logic        berr_ignore;
    logic        bus_fault_req;
    logic        lockup;
    logic        quot_zero;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // expected image: {uf_req, uf_cause, berr_ignore, bus_fault_req, lockup, reg_rdata}
    typedef struct {
        logic [37:0] img;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // bench model state
    logic [31:0] m_cfg;
    logic [1:0]  m_cause;
    logic        m_lock;

    always #2 clk = ~clk;

    fault_cfg_unit i_fault_cfg_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_size(acc_size),
        .acc_addr_lo(acc_addr_lo), .acc_multi(acc_multi), .div_valid(div_valid),
        .div_zero(div_zero), .berr_valid(berr_valid), .exec_prio(exec_prio),
        .cause_clr(cause_clr), .uf_req(uf_req), .uf_cause(uf_cause),
        .berr_ignore(berr_ignore), .bus_fault_req(bus_fault_req),
        .lockup(lockup), .quot_zero(quot_zero)
    );

    function automatic logic [37:0] act_img();
        return {uf_req, uf_cause, berr_ignore, bus_fault_req, lockup, reg_rdata};
    endfunction

    // monitor: compares one scoreboard entry per clock, after the edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (act_img() !== e.img) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", e.tag, act_img(), e.img);
            end
        end
    end

    task automatic step(input bit av, input int sz, input int al, input bit mu,
                        input bit dv, input bit dz, input bit bv, input int pr,
                        input int cl, input bit we, input logic [31:0] wd,
                        input string tag);
        bit   ua, ua_f, dz_f, qz, neg, ign, bfr;
        exp_t e;
        @(negedge clk);
        acc_valid = av; acc_size = sz[1:0]; acc_addr_lo = al[1:0]; acc_multi = mu;
        div_valid = dv; div_zero = dz; berr_valid = bv; exec_prio = pr[7:0];
        cause_clr = cl[1:0]; reg_we = we; reg_wdata = wd;
        ua   = av && (mu ? (al != 0) : ((sz == 1 && al[0]) || (sz == 2 && al != 0)));
        ua_f = ua && (mu || m_cfg[3]);
        dz_f = dv && dz && m_cfg[4];
        qz   = dv && dz && !m_cfg[4];
        neg  = (pr < 0);
        ign  = !m_lock && bv && neg && m_cfg[8];
        bfr  = !m_lock && bv && !neg;
        m_lock  = m_lock || (bv && neg && !m_cfg[8]);
        m_cause = (m_cause & ~cl[1:0]) | {dz_f, ua_f};
        if (we) m_cfg = wd & MASK;
        #1;
        checks++;
        if (quot_zero !== qz) begin
            errors++;
            $display("FAIL %s quot_zero: actual=%b expected=%b", tag, quot_zero, qz);
        end
        e.img = {ua_f || dz_f, m_cause, ign, bfr, m_lock, m_cfg};
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, tag);
    endtask
    task automatic acc(input int sz, input int al, input bit mu, input string tag);
        step(1, sz, al, mu, 0, 0, 0, 0, 0, 0, 32'h0, tag);
    endtask
    task automatic wr(input logic [31:0] d, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d, tag);
    endtask
    task automatic berr(input int pr, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, pr, 0, 0, 32'h0, tag);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        acc_valid = 0; div_valid = 0; berr_valid = 0; reg_we = 0; cause_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cfg = 32'h200; m_cause = '0; m_lock = 1'b0;
        checks++;
        if (act_img() !== {6'b0, 32'h200}) begin
            errors++;
            $display("FAIL R1 reset: actual=%h expected=%h", act_img(), {6'b0, 32'h200});
        end
    endtask

    initial begin
        do_reset();
        wr(32'hFFFF_FFFF, "R2 mask all-ones");
        idle("R2 readback");
        wr(32'h0, "R2 write zero");
        acc(1, 1, 0, "R3 half odd, trap off");
        acc(2, 2, 0, "R3 word off, trap off");
        acc(2, 2, 1, "R4 multi unaligned, trap off");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0, "R7 clear unaligned");
        wr(32'h8, "R3 enable trap");
        acc(0, 3, 0, "R3 byte never unaligned");
        acc(1, 2, 0, "R3 half aligned");
        acc(1, 1, 0, "R3 half odd, trap on");
        idle("R8 pulse ends, R7 flag held");
        acc(2, 0, 0, "R3 word aligned");
        acc(2, 1, 1, "R4 multi unaligned, trap on");
        acc(2, 1, 1, "R8 back-to-back pulse");
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 32'h0, "R5 div zero no trap");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 32'h0, "R5 div nonzero");
        wr(32'h10, "R6 enable div trap");
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 32'h0, "R6 div zero trapped");
        step(0, 0, 0, 0, 1, 1, 0, 0, 2, 0, 32'h0, "R7 set wins over clear");
        step(0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 32'h0, "R7 clear both");
        berr(0, "R11 prio 0, skip off");
        wr(32'h100, "R10 enable skip");
        berr(3, "R11 prio 3, skip on");
        berr(-1, "R10 prio -1 ignored");
        berr(-2, "R10 prio -2 ignored");
        wr(32'h0, "R9 disable skip");
        berr(-1, "R9 lockup");
        idle("R9 lockup held");
        berr(0, "R9 no response while locked");
        idle("R9 still locked");
        do_reset();
        idle("R1 after second reset");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule